// File: doc/BRIEF.md
# Chainable Serial Command and Fault Readback Port

This block is the serial slave of a four-channel low-side gate predriver. A controller lowers chip-select to open a frame. At that moment the block takes a snapshot of the live per-channel fault vector into its shift register and starts driving the serial output. Each serial clock then does two things. The rising edge samples one command bit from the serial input. The falling edge presents the next bit on the serial output. When chip-select rises, the four most recently received bits become the channel command register, and the serial output is released.

Several ports can be wired in a chain: one device's serial output feeds the next device's serial input. After its four fault bits, each device passes on the command bits it received. A chain of N devices therefore takes 4·N bits per frame, and each device keeps only the last four it saw. The chip-select, serial clock and serial data pins are asynchronous to the system clock. They are synchronized, and their edges are found by sampling, so the serial clock must run at least four times slower than the system clock. The output pair `sdo`/`sdo_oe` stands for a three-state pin. While the enable is low, `sdo` is held at 0.

Top module: `chain_cmd_port`

## Requirements
- R1: An active-low asynchronous reset clears the command register (all channels off), deasserts `sdo_oe` and drives `sdo` to 0, including in the middle of a frame.
- R2: After a falling edge on `cs_n`, `sdo_oe` is 1 and `sdo` shows fault bit 3 (channel 3) of the vector present at that edge. A 1 fault bit means that channel has a fault.
- R3: Changes of `faults` while `cs_n` is low do not alter the fault bits read out in that frame.
- R4: Fault bits leave MSB first (channel 3, 2, 1, 0). `sdo` advances only on a falling `sclk` edge, and `sdi` is taken on a rising `sclk` edge.
- R5: A rising edge on `cs_n` loads the last four received bits into `cmd`. The first of those four lands in `cmd[3]` and the last in `cmd[0]`. A 1 bit turns that channel on. `cmd` does not change at any other time except reset.
- R6: After a rising edge on `cs_n`, `sdo_oe` is 0.
- R7: In a frame longer than four bits, the bits received emerge on `sdo` in order after the four fault bits. `cmd` takes only the final four bits.
- R8: `sclk` activity while `cs_n` is high changes neither `cmd` nor `sdo_oe`.
- R9: While `sdo_oe` is 0, `sdo` is 0.
- R10: In a frame of fewer than four bits, `cmd` takes the shift contents: the unshifted low fault bits move to the upper positions and the received bits fill the low positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial command data in |
| faults | input | N | Live per-channel fault flags |
| sdo | output | 1 | Serial fault / pass-through data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| cmd | output | N | Channel command register |

## Verification
The assertions assume two things about the stimulus. First, `faults` is steady for a few system clocks around the falling edge of `cs_n`. Second, no `sclk` edge reaches the synchronizer in the same sampling cycle as a `cs_n` edge. The bench keeps both true: it holds every level for at least three system clocks before the next edge, changes `faults` only after the snapshot has been read, and keeps `sclk` low across every chip-select transition.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
  // One-cycle strobes from the control logic to the datapath.
  typedef struct packed {
    logic capture;   // chip-select fell: take fault snapshot
    logic shiftIn;   // serial clock rose inside a frame
    logic shiftOut;  // serial clock fell inside a frame
    logic commit;    // chip-select rose: load command
  } strobe_t;
endpackage

// File: rtl/cmdport_ctrl.sv
module cmdport_ctrl
  import cmdport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_n,
  input  logic    sclk,
  input  logic    sdi,
  output strobe_t strb,
  output logic    sdiSync,
  output logic    csIdle
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] csPipe, sclkPipe, sdiPipe;
  logic csPrev, sclkPrev;
  logic csSync, sclkSync, inFrame;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          csPipe   <= '1;
          sclkPipe <= '0;
          sdiPipe  <= '0;
        end else begin
          csPipe   <= {csPipe[TOP-1:0], cs_n};
          sclkPipe <= {sclkPipe[TOP-1:0], sclk};
          sdiPipe  <= {sdiPipe[TOP-1:0], sdi};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          csPipe   <= '1;
          sclkPipe <= '0;
          sdiPipe  <= '0;
        end else begin
          csPipe   <= cs_n;
          sclkPipe <= sclk;
          sdiPipe  <= sdi;
        end
      end
    end
  endgenerate

  assign csSync   = csPipe[TOP];
  assign sclkSync = sclkPipe[TOP];
  assign sdiSync  = sdiPipe[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csSync;
      sclkPrev <= sclkSync;
    end
  end

  assign inFrame = !csSync && !csPrev;

  always_comb begin
    strb.capture  = csPrev && !csSync;
    strb.commit   = !csPrev && csSync;
    strb.shiftIn  = inFrame && sclkSync && !sclkPrev;
    strb.shiftOut = inFrame && !sclkSync && sclkPrev;
  end

  assign csIdle = csSync;
endmodule

// File: rtl/cmdport_dp.sv
module cmdport_dp
  import cmdport_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      strb,
  input  logic         sdiSync,
  input  logic [N-1:0] faults,
  output logic         sdo,
  output logic         sdoOe,
  output logic [N-1:0] cmd
);
  logic [N-1:0] shReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg <= '0;
      cmd   <= '0;
      sdo   <= 1'b0;
      sdoOe <= 1'b0;
    end else if (strb.capture) begin
      shReg <= faults;
      sdo   <= faults[N-1];
      sdoOe <= 1'b1;
    end else if (strb.shiftIn) begin
      shReg <= {shReg[N-2:0], sdiSync};
    end else if (strb.shiftOut) begin
      sdo <= shReg[N-1];
    end else if (strb.commit) begin
      cmd   <= shReg;
      sdo   <= 1'b0;
      sdoOe <= 1'b0;
    end
  end
endmodule

// File: rtl/chain_cmd_port.sv
module chain_cmd_port
  import cmdport_pkg::*;
#(
  parameter int N           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         sdi,
  input  logic [N-1:0] faults,
  output logic         sdo,
  output logic         sdo_oe,
  output logic [N-1:0] cmd
);
  strobe_t strb;
  logic    sdiSync;
  logic    csIdle;

  cmdport_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .strb(strb), .sdiSync(sdiSync), .csIdle(csIdle)
  );

  cmdport_dp #(.N(N)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .sdiSync(sdiSync),
    .faults(faults), .sdo(sdo), .sdoOe(sdo_oe), .cmd(cmd)
  );
endmodule

// File: rtl/chain_cmd_port_chk.sv
module chain_cmd_port_chk
  import cmdport_pkg::*;
#(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] faults,
  input logic         sdo,
  input logic         sdo_oe,
  input logic [N-1:0] cmd,
  input strobe_t      strb,
  input logic         csIdle
);
  AST_IDLE_SDO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo); // R9

  AST_CAPTURE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> sdo_oe); // R2

  AST_CAPTURE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> (sdo == $past(faults[N-1]))); // R2

  AST_COMMIT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |=> !sdo_oe); // R6

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.commit |=> $stable(cmd)); // R5

  AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !strb.shiftOut && !strb.commit) |=> $stable(sdo)); // R4

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    csIdle |-> !(strb.shiftIn || strb.shiftOut)); // R8
endmodule

bind chain_cmd_port chain_cmd_port_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .faults(faults), .sdo(sdo), .sdo_oe(sdo_oe),
  .cmd(cmd), .strb(strb), .csIdle(csIdle)
);

// File: tb/chain_cmd_port_tb_top.sv
module chain_cmd_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int HOLD       = 6;
  localparam int NVEC       = 6;

  // Vector: {fault snapshot, fault value applied mid-frame, command bits}
  localparam logic [11:0] VECS [NVEC] = '{
    12'b1010_0101_1100,
    12'b0000_1111_1111,
    12'b1111_0000_0000,
    12'b0001_1110_1001,
    12'b1000_0111_0110,
    12'b0110_1001_0011
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [N-1:0] faults = '0;
  logic sdo, sdo_oe;
  logic [N-1:0] cmd;
  int vecs = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_cmd_port #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .faults(faults), .sdo(sdo), .sdo_oe(sdo_oe), .cmd(cmd)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs one frame; seen[k] is sdo before rising edge k, seen[nb] after the last fall.
  task automatic runFrame(input logic [N-1:0] f, input logic [N-1:0] fLater,
                          input int nb, input logic [7:0] data,
                          output logic [8:0] seen);
    seen = '0;
    faults = f;
    waitClk(HOLD);
    cs_n = 1'b0;
    waitClk(HOLD);
    check("R2 oe after select", {7'd0, sdo_oe}, 8'd1);
    faults = fLater;
    for (int k = 0; k < nb; k++) begin
      seen[k] = sdo;
      sdi = data[nb-1-k];
      waitClk(3);
      sclk = 1'b1;
      waitClk(3);
      check("R4 sdo steady on rise", {7'd0, sdo}, {7'd0, seen[k]});
      waitClk(HOLD - 3);
      sclk = 1'b0;
      waitClk(HOLD);
    end
    seen[nb] = sdo;
    cs_n = 1'b1;
    waitClk(HOLD);
    check("R6 oe after deselect", {7'd0, sdo_oe}, 8'd0);
    check("R9 sdo low when idle", {7'd0, sdo}, 8'd0);
  endtask

  // Reference shift model of the requirements.
  function automatic logic [N-1:0] expCmd(input logic [N-1:0] f, input int nb,
                                          input logic [7:0] data);
    logic [N-1:0] t = f;
    for (int k = 0; k < nb; k++) t = {t[N-2:0], data[nb-1-k]};
    return t;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin : main
    logic [8:0] seen;
    logic [N-1:0] prevCmd;
    waitClk(3);
    check("R1 reset cmd", {4'd0, cmd}, 8'd0);
    check("R1 reset oe", {7'd0, sdo_oe}, 8'd0);
    rst_n = 1'b1;
    waitClk(4);

    // Table-driven 4-bit frames: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      logic [N-1:0] f, fl, d;
      {f, fl, d} = VECS[v];
      runFrame(f, fl, 4, {4'd0, d}, seen);
      for (int k = 0; k < 4; k++)
        check("R3 R4 fault order", {7'd0, seen[k]}, {7'd0, f[3-k]});
      check("R5 command", {4'd0, cmd}, {4'd0, d});
    end

    // R7: 8-bit chained frame, pass-through after faults
    runFrame(4'b1001, 4'b0110, 8, 8'b1101_0010, seen);
    for (int k = 0; k < 4; k++)
      check("R7 fault part", {7'd0, seen[k]}, {7'd0, 1'(4'b1001 >> (3-k))});
    for (int k = 4; k < 8; k++)
      check("R7 pass-through", {7'd0, seen[k]}, {7'd0, 1'(8'b1101_0010 >> (11-k))});
    check("R7 last bit through", {7'd0, seen[8]}, {7'd0, 1'b0});
    check("R7 last four kept", {4'd0, cmd}, 8'b0000_0010);

    // R10: short frame of two bits
    runFrame(4'b0110, 4'b0000, 2, 8'b0000_0011, seen);
    check("R10 short frame", {4'd0, cmd}, {4'd0, expCmd(4'b0110, 2, 8'b11)});

    // R8: serial clock toggled while deselected
    prevCmd = cmd;
    for (int k = 0; k < 5; k++) begin
      sdi = 1'b1; sclk = 1'b1; waitClk(HOLD);
      sclk = 1'b0; waitClk(HOLD);
      check("R8 oe stays off", {7'd0, sdo_oe}, 8'd0);
    end
    check("R8 cmd unchanged", {4'd0, cmd}, {4'd0, prevCmd});
    sdi = 1'b0;

    // R1: reset in the middle of a frame
    runFrame(4'b0000, 4'b0000, 4, 8'b0000_1111, seen);
    check("R5 all on", {4'd0, cmd}, 8'h0F);
    cs_n = 1'b0;
    waitClk(HOLD);
    sdi = 1'b1; sclk = 1'b1; waitClk(HOLD); sclk = 1'b0; waitClk(2);
    rst_n = 1'b0;
    waitClk(1);
    check("R1 mid-frame cmd", {4'd0, cmd}, 8'd0);
    check("R1 mid-frame oe", {7'd0, sdo_oe}, 8'd0);
    check("R1 mid-frame sdo", {7'd0, sdo}, 8'd0);
    cs_n = 1'b1; sdi = 1'b0;
    waitClk(HOLD);
    rst_n = 1'b1;
    waitClk(HOLD);
    check("R1 after release", {4'd0, cmd}, 8'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule